// File: doc/BRIEF.md
# Programmable-Width Video Word Serializer

This block turns parallel pixel words into a serial bit stream, one serial word per captured pixel word. Each pixel word holds up to sixteen data bits and the horizontal and vertical sync levels. A strobe input marks when a word is present. The block captures the word on the strobe's rising or falling edge, whichever is selected. It then shifts the word out one bit per cycle in which the bit-rate enable is high. The bit-rate enable comes from the same system clock, so the serial bit rate is the pixel rate times the serial word length.

The serial word length can be 12, 14, 16, 18 or 20 bits. Every serial word starts with a four-bit header: two framing bits that are always 1 then 0, then HSYNC, then VSYNC. The data bits follow, lowest first. The number of data bits is the word length minus four. Data inputs above that count are not serialized; they appear on a general-purpose output bus instead. The length in force is latched when a word is captured, so a change of width setting takes effect only at a word boundary. A word whose capture edge arrives while the previous word is still being shifted out is dropped, and a one-cycle overrun pulse is raised.

Top module: `svw_serializer`

## Requirements
- R1: The serial word length is 12, 14, 16, 18 or 20 bits for `width_sel` = 0, 1, 2, 3 and 4. Values 5 to 7 give 20 bits. Exactly that many bits are emitted per captured word.
- R2: Bits leave in this order. Serial bit 1 is a constant 1 and bit 2 is a constant 0. Bit 3 is the captured HSYNC and bit 4 is the captured VSYNC. Bit 5 onward carry D0, D1, D2 and so on.
- R3: A word carries `len - 4` data bits, D0 upward. Data inputs at or above that index never reach `ser_bit`.
- R4: `gpio_out[i]` equals `pix_data[i]` for every index `i` at or above `len - 4` for the current `width_sel`, and is 0 below it. This path is combinational.
- R5: With `cap_fall` = 0 a word is captured on the clock edge where `pix_stb` is first seen high after being low. With `cap_fall` = 1 it is captured on the edge where `pix_stb` is first seen low after being high.
- R6: One bit is emitted on each clock edge where `bit_en` is high and bits remain. `ser_vld` is high for exactly those bits. `ser_first` is high only with the first bit of a word. With `ser_vld` low, `ser_bit` is 0.
- R7: The word length and content are fixed at capture. Changing `width_sel` or the data inputs while a word is shifting does not change that word.
- R8: A capture edge while bits of the previous word remain raises `overrun` for one cycle, registered on that edge. The new word is discarded and never emitted.
- R9: After synchronous reset, `ser_bit`, `ser_vld`, `ser_first` and `overrun` are 0 and no word is pending.
- R10: The first bit of a captured word appears on the first `bit_en` edge after the capture edge. With `bit_en` held high, that is one clock after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| pix_stb | input | 1 | Pixel word strobe; its selected edge captures a word |
| cap_fall | input | 1 | Capture edge select: 0 rising, 1 falling |
| width_sel | input | 3 | Serial word length select (see R1) |
| pix_data | input | 16 | Parallel pixel data D0..D15 |
| hsync | input | 1 | Horizontal sync level to send |
| vsync | input | 1 | Vertical sync level to send |
| ser_bit | output | 1 | Serial data bit |
| ser_vld | output | 1 | High when `ser_bit` carries a bit |
| ser_first | output | 1 | Marks the first bit of a serial word |
| overrun | output | 1 | One-cycle pulse when a word is dropped |
| gpio_out | output | 16 | Data inputs released as general-purpose at this width |

## Verification
A corrupted bit counter shows up as a word that is too short or too long. It is seen at the ports within one word time: either a `ser_first` arrives early, or `ser_vld` pulses continue after the expected last bit. A shift register that is loaded wrongly or misaligned breaks the fixed 1-0 framing pair or shifts the sync and data positions. Comparing every bit of every word catches this on the first bad word. A broken capture or busy decision shows up one clock after the strobe edge, as a missing or extra `overrun` pulse or as a dropped word that is emitted anyway.

// File: rtl/svw_pkg.sv
package svw_pkg;

    localparam int DATA_W   = 16;
    localparam int HDR_W    = 4;
    localparam int WORD_MAX = DATA_W + HDR_W;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        LEN12 = 3'd0,
        LEN14 = 3'd1,
        LEN16 = 3'd2,
        LEN18 = 3'd3,
        LEN20 = 3'd4
    } len_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vsync;
        logic              hsync;
    } pix_word_t;

    // serial word length for a width setting; out-of-range codes use the longest
    function automatic logic [CNT_W-1:0] word_len(input logic [SEL_W-1:0] sel);
        case (len_sel_e'(sel))
            LEN12:   return CNT_W'(12);
            LEN14:   return CNT_W'(14);
            LEN16:   return CNT_W'(16);
            LEN18:   return CNT_W'(18);
            default: return CNT_W'(20);
        endcase
    endfunction

    // ones on the data inputs that are serialized at this width
    function automatic logic [DATA_W-1:0] data_mask(input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] m;
        int                nb;
        nb = int'(word_len(sel)) - HDR_W;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < nb);
        end
        return m;
    endfunction

    // LSB leaves first: framing 1, framing 0, hsync, vsync, D0 upward
    function automatic logic [WORD_MAX-1:0] build_word(input pix_word_t p,
                                                       input logic [SEL_W-1:0] sel);
        return {p.data & data_mask(sel), p.vsync, p.hsync, 1'b0, 1'b1};
    endfunction

endpackage

// File: rtl/svw_edge_cap.sv
module svw_edge_cap (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic fall_sel,
    output logic cap
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= stb;
        end
    end

    always_comb begin
        if (fall_sel) begin
            cap = stb_q & ~stb;
        end else begin
            cap = ~stb_q & stb;
        end
    end
endmodule

// File: rtl/svw_shifter.sv
module svw_shifter #(
    parameter int WORD_W = svw_pkg::WORD_MAX,
    parameter int CNT_W  = svw_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              bit_en,
    output logic              ser_bit,
    output logic              ser_vld,
    output logic              ser_first,
    output logic              overrun
);
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  left;
    logic              first_pend;
    logic              busy;

    assign busy = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            left       <= '0;
            first_pend <= 1'b0;
            ser_bit    <= 1'b0;
            ser_vld    <= 1'b0;
            ser_first  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            overrun <= load & busy;
            if (bit_en && busy) begin
                ser_bit    <= sh[0];
                ser_vld    <= 1'b1;
                ser_first  <= first_pend;
                first_pend <= 1'b0;
                sh         <= sh >> 1;
                left       <= left - CNT_W'(1);
            end else begin
                ser_bit   <= 1'b0;
                ser_vld   <= 1'b0;
                ser_first <= 1'b0;
            end
            if (load && !busy) begin
                sh         <= load_word;
                left       <= load_len;
                first_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/svw_gpio_map.sv
module svw_gpio_map #(
    parameter int DATA_W = svw_pkg::DATA_W,
    parameter int SEL_W  = svw_pkg::SEL_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] gpio
);
    logic [DATA_W-1:0] used;

    assign used = svw_pkg::data_mask(sel);

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pin
        assign gpio[gi] = used[gi] ? 1'b0 : data[gi];
    end
endmodule

// File: rtl/svw_serializer.sv
module svw_serializer #(
    parameter int DATA_W = svw_pkg::DATA_W,
    parameter int SEL_W  = svw_pkg::SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              pix_stb,
    input  logic              cap_fall,
    input  logic [SEL_W-1:0]  width_sel,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              hsync,
    input  logic              vsync,
    output logic              ser_bit,
    output logic              ser_vld,
    output logic              ser_first,
    output logic              overrun,
    output logic [DATA_W-1:0] gpio_out
);
    import svw_pkg::*;

    localparam int WORD_W = DATA_W + HDR_W;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    logic               cap;
    pix_word_t          pix;
    logic [WORD_W-1:0]  word;
    logic [LEN_W-1:0]   len;

    assign pix.data  = pix_data;
    assign pix.vsync = vsync;
    assign pix.hsync = hsync;
    assign word      = build_word(pix, width_sel);
    assign len       = word_len(width_sel);

    svw_edge_cap u_cap (
        .clk      (clk),
        .rst      (rst),
        .stb      (pix_stb),
        .fall_sel (cap_fall),
        .cap      (cap)
    );

    svw_shifter #(
        .WORD_W (WORD_W),
        .CNT_W  (LEN_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (cap),
        .load_word (word),
        .load_len  (len),
        .bit_en    (bit_en),
        .ser_bit   (ser_bit),
        .ser_vld   (ser_vld),
        .ser_first (ser_first),
        .overrun   (overrun)
    );

    svw_gpio_map #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_gpio (
        .data (pix_data),
        .sel  (width_sel),
        .gpio (gpio_out)
    );
endmodule

// File: rtl/svw_checker.sv
module svw_checker (
    input logic        clk,
    input logic        rst,
    input logic        bit_en,
    input logic [2:0]  width_sel,
    input logic [15:0] gpio_out,
    input logic        ser_bit,
    input logic        ser_vld,
    input logic        ser_first,
    input logic        overrun
);
    logic [4:0]  pos;
    logic        seen;
    logic [15:0] low_mask;
    int          ndata;

    always_comb begin
        case (width_sel)
            3'd0:    ndata = 8;
            3'd1:    ndata = 10;
            3'd2:    ndata = 12;
            3'd3:    ndata = 14;
            default: ndata = 16;
        endcase
        for (int i = 0; i < 16; i++) begin
            low_mask[i] = (i < ndata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            seen <= 1'b0;
        end else if (ser_vld) begin
            pos  <= ser_first ? 5'd1 : pos + 5'd1;
            seen <= seen | ser_first;
        end
    end

    p_first_has_vld_r6: assert property (@(posedge clk) disable iff (rst)
        ser_first |-> ser_vld);

    p_vld_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        ser_vld |-> $past(bit_en));

    p_frame_one_r2: assert property (@(posedge clk) disable iff (rst)
        ser_first |-> ser_bit);

    p_frame_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_vld && !ser_first && seen && pos == 5'd1) |-> !ser_bit);

    p_min_len_r1: assert property (@(posedge clk) disable iff (rst)
        (ser_first && seen) |-> (pos >= 5'd12));

    p_max_len_r1: assert property (@(posedge clk) disable iff (rst)
        (ser_vld && !ser_first && seen) |-> (pos < 5'd20));

    p_gpio_low_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (gpio_out & low_mask) == 16'h0000);

    p_overrun_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);
endmodule

bind svw_serializer svw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .width_sel (width_sel),
    .gpio_out  (gpio_out),
    .ser_bit   (ser_bit),
    .ser_vld   (ser_vld),
    .ser_first (ser_first),
    .overrun   (overrun)
);

// File: tb/sim_svw_serializer.sv
`timescale 1ns/1ps
module sim_svw_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        pix_stb = 1'b0;
    logic        cap_fall = 1'b0;
    logic [2:0]  width_sel = 3'd0;
    logic [15:0] pix_data = 16'h0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        ser_bit, ser_vld, ser_first, overrun;
    logic [15:0] gpio_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    svw_serializer u0 (
        .clk (clk), .rst (rst), .bit_en (bit_en), .pix_stb (pix_stb),
        .cap_fall (cap_fall), .width_sel (width_sel), .pix_data (pix_data),
        .hsync (hsync), .vsync (vsync), .ser_bit (ser_bit), .ser_vld (ser_vld),
        .ser_first (ser_first), .overrun (overrun), .gpio_out (gpio_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int sel);
        case (sel)
            0: return 12;
            1: return 14;
            2: return 16;
            3: return 18;
            default: return 20;
        endcase
    endfunction

    function automatic logic exp_bit(input int k, input logic [15:0] d,
                                     input logic h, input logic v);
        if (k == 0) return 1'b1;
        if (k == 1) return 1'b0;
        if (k == 2) return h;
        if (k == 3) return v;
        return d[k-4];
    endfunction

    function automatic logic roll(input int pct);
        return ($urandom_range(99) < pct);
    endfunction

    // drives one word, collects its bits and checks them
    task automatic send_word(input logic [15:0] d, input logic h, input logic v,
                             input int sel, input logic fall, input int en_pct,
                             input bit lat_chk, input int chg_at, input int chg_sel,
                             input int ovr_at);
        int len = exp_len(sel);
        int got = 0;
        int cyc = 0;
        int bad = 0;
        int badfirst = 0;
        int first_cyc = -1;
        int extra = 0;
        bit ovr_seen = 1'b0;
        @(negedge clk);
        pix_data  = d;
        hsync     = h;
        vsync     = v;
        width_sel = 3'(sel);
        cap_fall  = fall;
        pix_stb   = 1'b1;
        bit_en    = roll(en_pct);
        while (got < len && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (ser_vld) begin
                if (ser_bit !== exp_bit(got, d, h, v)) bad++;
                if (ser_first !== (got == 0)) badfirst++;
                if (got == 0) first_cyc = cyc;
                got++;
            end else if (ser_first || ser_bit) begin
                badfirst++;
            end
            if (overrun) ovr_seen = 1'b1;
            if (cyc == 1) pix_stb = 1'b0;
            if (cyc == chg_at) width_sel = 3'(chg_sel);
            if (ovr_at > 0 && cyc == ovr_at) begin
                pix_stb  = 1'b1;
                pix_data = ~d;
            end
            if (ovr_at > 0 && cyc == ovr_at + 1) pix_stb = 1'b0;
            bit_en = roll(en_pct);
        end
        bit_en = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (ser_vld) extra++;
            if (overrun) ovr_seen = 1'b1;
        end
        bit_en = 1'b0;
        check(got == len, "R1", "bits per word", got, len);
        check(bad == 0, "R2/R3", "wrong bits (header, order or data)", bad, 0);
        check(badfirst == 0, "R6", "first-bit marker or idle bit errors", badfirst, 0);
        check(extra == 0, "R7/R8", "bits after word end", extra, 0);
        check(ovr_seen == (ovr_at > 0), "R8", "overrun seen", int'(ovr_seen), int'(ovr_at > 0));
        if (lat_chk)
            check(first_cyc == (fall ? 3 : 2), "R5/R10", "first bit cycle", first_cyc, fall ? 3 : 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser_vld == 1'b0 && ser_first == 1'b0 && ser_bit == 1'b0, "R9",
              "outputs after reset", int'({ser_vld, ser_first, ser_bit}), 0);
        check(overrun == 1'b0, "R9", "overrun after reset", int'(overrun), 0);

        // R1 R2 R3 R10: every width code, rising capture, enable held high
        for (int s = 0; s < 8; s++) begin
            send_word(16'($urandom), 1'($urandom), 1'($urandom), s, 1'b0, 100, 1'b1, -1, 0, 0);
        end
        // R2: extreme data patterns
        send_word(16'hFFFF, 1'b1, 1'b1, 4, 1'b0, 100, 1'b1, -1, 0, 0);
        send_word(16'h0000, 1'b0, 1'b0, 3, 1'b0, 100, 1'b1, -1, 0, 0);
        // R5: falling capture
        for (int s = 0; s < 5; s++) begin
            send_word(16'($urandom), 1'($urandom), 1'($urandom), s, 1'b1, 100, 1'b1, -1, 0, 0);
        end
        // R7: width change mid-word, both directions
        send_word(16'hA5C3, 1'b1, 1'b0, 0, 1'b0, 100, 1'b1, 4, 4, 0);
        send_word(16'h3C5A, 1'b0, 1'b1, 4, 1'b0, 100, 1'b1, 5, 0, 0);
        // R8: second strobe while shifting, both edge modes
        send_word(16'h1234, 1'b1, 1'b1, 2, 1'b0, 100, 1'b1, -1, 0, 4);
        send_word(16'h8001, 1'b0, 1'b1, 1, 1'b1, 100, 1'b1, -1, 0, 5);
        // R6: random stimulus with a sparse bit enable
        for (int n = 0; n < 40; n++) begin
            send_word(16'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(7)),
                      1'($urandom), int'($urandom_range(90, 20)), 1'b0, -1, 0, 0);
        end
        // R6: no bits without the enable
        bit_en = 1'b0;
        pix_data = 16'h5555;
        cap_fall = 1'b0;
        width_sel = 3'd0;
        @(negedge clk) pix_stb = 1'b1;
        @(negedge clk) pix_stb = 1'b0;
        begin
            int cnt = 0;
            repeat (10) begin
                @(negedge clk);
                if (ser_vld) cnt++;
            end
            check(cnt == 0, "R6", "bits with enable low", cnt, 0);
            bit_en = 1'b1;
            cnt = 0;
            repeat (16) begin
                @(negedge clk);
                if (ser_vld) cnt++;
            end
            bit_en = 1'b0;
            check(cnt == 12, "R6", "bits once enabled", cnt, 12);
        end
        // R4: general-purpose mapping for every width code
        for (int s = 0; s < 8; s++) begin
            logic [15:0] d;
            logic [15:0] e;
            d = 16'($urandom) | 16'h8001;
            width_sel = 3'(s);
            pix_data  = d;
            #1;
            e = d & ~16'((32'd1 << (exp_len(s) - 4)) - 1);
            check(gpio_out == e, "R4", "gpio_out", int'(gpio_out), int'(e));
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule